// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Standard or Fall-Through Read Timing

This block is a first-in first-out buffer that carries 36-bit words from a write clock domain to an unrelated read clock domain. Words are stored in a small array. The write and read pointers cross between the domains as gray code, through two flip-flop stages in each direction. The block has one master reset, `mrst`, which is synchronous in both domains. While that reset is held, the input `mode_sel` chooses how the read side behaves: low gives standard timing and high gives fall-through timing. The choice is latched and stays fixed until the next master reset.

In standard timing, each word comes out on `q` only when the reader asks for it. The two shared status pins then mean "empty" (`rd_status`) and "full" (`wr_status`).

In fall-through timing, the oldest word moves onto `q` by itself. The status pins then mean "output valid" (`rd_status`) and "room to write" (`wr_status`). The output register counts as one extra storage slot.

The read side is a three-state machine:
- `RS_STD` is the standard-timing state and is the only state used in that mode.
- `RS_FT_DRY` means fall-through with nothing valid on `q`.
- `RS_FT_HOLD` means fall-through with a valid word on `q`.

Its transitions are:
- Reset enters `RS_STD` when `mode_sel` is low, and `RS_FT_DRY` when it is high.
- `RS_STD` stays in `RS_STD`. A read request while the array is not empty loads `q` with the next word.
- **load**: `RS_FT_DRY` goes to `RS_FT_HOLD` as soon as the array is not empty. The head word is loaded into `q`.
- **advance**: `RS_FT_HOLD` stays in `RS_FT_HOLD` on a read request when the array still holds words. The next word is loaded.
- **drain**: `RS_FT_HOLD` goes to `RS_FT_DRY` on a read request when the array is empty.
- **hold**: `RS_FT_HOLD` stays in `RS_FT_HOLD` without a read request, and `q` is unchanged.

Top module: `dual_mode_fifo`

## Requirements
- R1: The level of `mode_sel` is captured only while `mrst` is high: 0 selects standard timing and 1 selects fall-through timing. Changing `mode_sel` after `mrst` falls has no effect. In particular, standard mode never presents a word on `q` without a read request, and fall-through mode always does.
- R2: Right after master reset, `q` is 0 in both modes. In standard mode `rd_status` is 1 (empty) and `wr_status` is 0 (not full). In fall-through mode `rd_status` is 0 (not valid) and `wr_status` is 1 (room).
- R3: In standard mode, `rd_status` is 0 only while a word is available. A rising `rclk` edge with `rd_en`=1 and `rd_status`=0 puts the oldest stored word on `q` after that edge. `q` holds that word until the next accepted read.
- R4: In standard mode, `wr_status` becomes 1 at the write edge that stores the DEPTH-th word while no reads take place. It returns to 0 a few write clocks after the reader removes words.
- R5: In fall-through mode, a word written into an empty buffer appears on `q`, with `rd_status`=1, right after the third rising `rclk` edge that follows the write edge. It does not appear earlier, and `rd_en` is not needed.
- R6: In fall-through mode, while `rd_status`=1, `q` changes only at a rising `rclk` edge with `rd_en`=1. That edge shows the next word, or clears `rd_status` when no word is left.
- R7: In fall-through mode, with the reader idle, exactly DEPTH+1 writes are accepted (the array plus the output register) before `wr_status` stays 0.
- R8: Some requests are ignored. In standard mode these are reads while empty and writes while full. In fall-through mode they are reads while not valid and writes while there is no room. An ignored request leaves `q`, the flags and the stored sequence unchanged.
- R9: Words leave in the order they were accepted, with none lost or repeated, while both clocks run together. A flag never reports data that is not there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in both domains |
| mode_sel | input | 1 | Read-timing select, sampled only during master reset |
| wr_en | input | 1 | Write request, sampled on rising `wclk` |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read request, sampled on rising `rclk` |
| q | output | WIDTH | Read data register |
| rd_status | output | 1 | Standard mode: empty. Fall-through mode: output valid |
| wr_status | output | 1 | Standard mode: full. Fall-through mode: room to write |

## Verification
The following faults show up at the ports.
- **Mis-latched mode.** The reset values of both status pins are wrong one cycle after reset is released, and the first word either falls through or fails to.
- **Wrong full compare, or a pointer that slips.** This appears at the fill boundary as one write too many or too few. It also appears later as a missing or duplicated word during draining, and the per-clock reference comparison flags it on the read clock where that word should have shown.
- **Bad fall-through state.** A state that drops or reloads the output register changes `q` on an idle read clock. That is caught on the very next read clock.
- **Synchronizer depth off by one.** This moves the first-word arrival away from the third read edge.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_FT  = 1'b1
    } mode_t;

    typedef enum logic [1:0] {
        RS_STD     = 2'd0,
        RS_FT_DRY  = 2'd1,
        RS_FT_HOLD = 2'd2
    } rd_state_t;

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
    import dmf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          mrst,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          wr_status,
    output mode_t         wmode
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [AW:0] wbin;
    logic [AW:0] wbin_nx;
    logic        arr_full;

    // Full when the write pointer is exactly one lap ahead of the synced read pointer.
    assign arr_full = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign we       = wr_en && !arr_full;
    assign wbin_nx  = wbin + 1'b1;
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (mrst) begin
            wmode <= mode_sel ? MODE_FT : MODE_STD;
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_comb begin
        unique case (wmode)
            MODE_STD: wr_status = arr_full;
            MODE_FT:  wr_status = !arr_full;
            default:  wr_status = arr_full;
        endcase
    end

    // Checker view: decode the synchronized read pointer back to binary.
    logic [AW:0] rbin_s;
    logic [AW:0] occ_w;
    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end
    assign occ_w = wbin - rbin_s;

    a_r8_no_overflow: assert property (@(posedge wclk) disable iff (mrst)
        occ_w <= DEPTH_V);

    a_r8_full_blocks_write: assert property (@(posedge wclk) disable iff (mrst)
        (arr_full && wr_en) |=> (wgray == $past(wgray)));

    a_r9_wgray_one_bit: assert property (@(posedge wclk) disable iff (mrst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
    import dmf_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             rclk,
    input  logic             mrst,
    input  logic             mode_sel,
    input  logic             rd_en,
    input  logic [AW:0]      wgray_s,
    input  logic [WIDTH-1:0] ram_q,
    output logic [AW:0]      rgray,
    output logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q,
    output logic             rd_status,
    output mode_t            rmode
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    rd_state_t   state;
    rd_state_t   state_nx;
    logic [AW:0] rbin;
    logic [AW:0] rbin_nx;
    logic        arr_empty;
    logic        pop;

    assign arr_empty = (rgray == wgray_s);
    assign rbin_nx   = rbin + 1'b1;
    assign raddr     = rbin[AW-1:0];

    // State register; the mode is captured here during master reset.
    always_ff @(posedge rclk) begin
        if (mrst) begin
            state <= mode_sel ? RS_FT_DRY : RS_STD;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and array pop.
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            RS_STD: begin
                pop = rd_en && !arr_empty;
            end
            RS_FT_DRY: begin
                if (!arr_empty) begin
                    pop      = 1'b1;
                    state_nx = RS_FT_HOLD;
                end
            end
            RS_FT_HOLD: begin
                if (rd_en) begin
                    if (!arr_empty) begin
                        pop = 1'b1;
                    end else begin
                        state_nx = RS_FT_DRY;
                    end
                end
            end
            default: state_nx = RS_STD;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state)
            RS_STD:     begin rd_status = arr_empty; rmode = MODE_STD; end
            RS_FT_DRY:  begin rd_status = 1'b0;      rmode = MODE_FT;  end
            RS_FT_HOLD: begin rd_status = 1'b1;      rmode = MODE_FT;  end
            default:    begin rd_status = 1'b1;      rmode = MODE_STD; end
        endcase
    end

    always_ff @(posedge rclk) begin
        if (mrst) begin
            rbin  <= '0;
            rgray <= '0;
            q     <= '0;
        end else if (pop) begin
            q     <= ram_q;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Checker view: occupancy as seen from the read side.
    logic [AW:0] wbin_s;
    logic [AW:0] occ_r;
    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end
    assign occ_r = wbin_s - rbin;

    a_r8_no_underflow: assert property (@(posedge rclk) disable iff (mrst)
        occ_r <= DEPTH_V);

    a_r6_hold_stable: assert property (@(posedge rclk) disable iff (mrst)
        (state == RS_FT_HOLD && !rd_en) |=> ($stable(q) && rd_status));

    a_r5_fall_load: assert property (@(posedge rclk) disable iff (mrst)
        (state == RS_FT_DRY && !arr_empty) |=> (rd_status && $changed(rgray)));

    a_r9_rgray_one_bit: assert property (@(posedge rclk) disable iff (mrst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 16
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             mode_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] q,
    output logic             rd_status,
    output logic             wr_status
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]      wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]    waddr, raddr;
    logic             we;
    logic [WIDTH-1:0] ram_q;
    mode_t            wmode, rmode;

    dmf_sync #(.W(AW+1)) u_w2r (
        .clk(rclk), .rst(mrst), .d(wgray), .q(wgray_s)
    );

    dmf_sync #(.W(AW+1)) u_r2w (
        .clk(wclk), .rst(mrst), .d(rgray), .q(rgray_s)
    );

    dmf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(ram_q)
    );

    dmf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .mrst(mrst), .mode_sel(mode_sel), .wr_en(wr_en),
        .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .we(we),
        .wr_status(wr_status), .wmode(wmode)
    );

    dmf_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .mrst(mrst), .mode_sel(mode_sel), .rd_en(rd_en),
        .wgray_s(wgray_s), .ram_q(ram_q), .rgray(rgray), .raddr(raddr),
        .q(q), .rd_status(rd_status), .rmode(rmode)
    );

    a_r1_modes_agree: assert property (@(posedge rclk) disable iff (mrst)
        wmode == rmode);
endmodule

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
    localparam int W = 36;
    localparam int D = 16;

    logic         wclk = 1'b0;
    logic         rclk = 1'b0;
    logic         mrst = 1'b1;
    logic         mode_sel = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         rd_status;
    logic         wr_status;

    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    bit           ft = 1'b0;
    bit           mon_on = 1'b0;
    bit           std_has = 1'b0;
    logic [W-1:0] std_last = '0;
    logic [W-1:0] model[$];

    dual_mode_fifo #(.WIDTH(W), .DEPTH(D)) dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .mode_sel(mode_sel),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .q(q),
        .rd_status(rd_status), .wr_status(wr_status)
    );

    // 125 MHz write clock; read clock 12 ns, offset so edges never coincide.
    always #4 wclk = ~wclk;
    initial begin
        #1;
        forever #6 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] head();
        return (model.size() > 0) ? model[0] : '0;
    endfunction

    // Reference comparison on every read clock.
    always @(posedge rclk) begin
        #2;
        if (mon_on && !mrst) begin
            if (ft) begin
                if (rd_status) chk(model.size() > 0 && q == head(), "R9 fall-through order", q, head());
            end else begin
                if (!rd_status) chk(model.size() > 0, "R9 empty flag conservative", W'(rd_status), '0);
                if (std_has) chk(q == std_last, "R3 q holds last read", q, std_last);
            end
        end
    end

    task automatic do_reset(input bit m);
        mon_on = 1'b0;
        mrst = 1'b1; mode_sel = m; wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        mrst = 1'b0;
        ft = m;
        model.delete();
        std_has = 1'b0;
        mode_sel = ~m;   // R1: must be ignored from here on
        mon_on = 1'b1;
    endtask

    task automatic wr_word(input logic [W-1:0] d);
        do @(negedge wclk); while (!(ft ? wr_status : !wr_status));
        wr_en = 1'b1; din = d;
        model.push_back(d);
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd_std();
        logic [W-1:0] e;
        do @(negedge rclk); while (rd_status);
        rd_en = 1'b1;
        @(posedge rclk);
        e = model.pop_front();
        std_last = e; std_has = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        chk(q == e, "R3 read returns oldest", q, e);
    endtask

    task automatic rd_ft();
        do @(negedge rclk); while (!rd_status);
        chk(q == head(), "R6 head on q", q, head());
        rd_en = 1'b1;
        @(posedge rclk);
        void'(model.pop_front());
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_sim();
    end

    initial begin
        int cnt;
        int idle;

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        #1;
        chk(rd_status == 1'b1, "R2 std empty", W'(rd_status), 1);
        chk(wr_status == 1'b0, "R2 std not full", W'(wr_status), 0);
        chk(q == '0, "R2 q zero", q, 0);

        @(negedge rclk) rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
        chk(q == '0, "R8 read on empty q unchanged", q, 0);
        chk(rd_status == 1'b1, "R8 read on empty flag", W'(rd_status), 1);

        for (int i = 0; i < 5; i++) wr_word(W'(36'h100 + i));
        repeat (6) @(negedge rclk);
        chk(q == '0, "R1 std needs request", q, 0);
        chk(rd_status == 1'b0, "R3 not empty", W'(rd_status), 0);
        for (int i = 0; i < 5; i++) rd_std();
        repeat (4) @(negedge rclk);
        chk(rd_status == 1'b1, "R3 empty after drain", W'(rd_status), 1);

        for (int i = 0; i < D - 1; i++) wr_word(W'(36'h200 + i));
        chk(wr_status == 1'b0, "R4 not full at DEPTH-1", W'(wr_status), 0);
        wr_word(W'(36'h200 + D - 1));
        chk(wr_status == 1'b1, "R4 full at DEPTH", W'(wr_status), 1);
        @(negedge wclk) begin wr_en = 1'b1; din = 36'hBAD; end
        @(negedge wclk) wr_en = 1'b0;
        chk(wr_status == 1'b1, "R8 write on full flag", W'(wr_status), 1);
        for (int i = 0; i < D; i++) rd_std();
        repeat (6) @(negedge wclk);
        chk(wr_status == 1'b0, "R4 full clears", W'(wr_status), 0);
        chk(rd_status == 1'b1, "R8 dropped word absent", W'(rd_status), 1);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        #1;
        chk(rd_status == 1'b0, "R2 ft not valid", W'(rd_status), 0);
        chk(wr_status == 1'b1, "R2 ft room", W'(wr_status), 1);
        chk(q == '0, "R2 ft q zero", q, 0);

        @(negedge wclk) begin wr_en = 1'b1; din = 36'hA5A5; model.push_back(36'hA5A5); end
        @(posedge wclk) wr_en <= 1'b0;
        @(posedge rclk); #2;
        chk(rd_status == 1'b0, "R5 not yet after edge 1", W'(rd_status), 0);
        @(posedge rclk); #2;
        chk(rd_status == 1'b0, "R5 not yet after edge 2", W'(rd_status), 0);
        @(posedge rclk); #2;
        chk(rd_status == 1'b1, "R5 valid after edge 3", W'(rd_status), 1);
        chk(q == 36'hA5A5, "R5 word on q", q, 36'hA5A5);

        repeat (5) @(negedge rclk);
        chk(q == 36'hA5A5 && rd_status, "R6 held without request", q, 36'hA5A5);
        rd_ft();
        repeat (3) @(negedge rclk);
        chk(rd_status == 1'b0, "R6 drain clears valid", W'(rd_status), 0);
        @(negedge rclk) rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
        chk(rd_status == 1'b0, "R8 read when not valid", W'(rd_status), 0);
        chk(q == 36'hA5A5, "R8 q unchanged", q, 36'hA5A5);
        wr_word(36'h77);
        repeat (6) @(negedge rclk);
        chk(rd_status && q == 36'h77, "R1 ft falls through", q, 36'h77);
        rd_ft();

        cnt = 0; idle = 0;
        while (idle < 20) begin
            @(negedge wclk);
            if (wr_status) begin
                wr_en = 1'b1; din = W'(36'h300 + cnt);
                model.push_back(W'(36'h300 + cnt));
                cnt++; idle = 0;
                @(negedge wclk);
                wr_en = 1'b0;
            end else begin
                idle++;
            end
        end
        chk(cnt == D + 1, "R7 capacity DEPTH+1", W'(cnt), W'(D + 1));
        @(negedge wclk) begin wr_en = 1'b1; din = 36'hBAD; end
        @(negedge wclk) wr_en = 1'b0;
        chk(wr_status == 1'b0, "R8 write without room", W'(wr_status), 0);
        for (int i = 0; i < D + 1; i++) rd_ft();
        repeat (8) @(negedge rclk);
        chk(rd_status == 1'b0, "R8 extra word dropped", W'(rd_status), 0);

        fork
            for (int i = 0; i < 40; i++) wr_word(W'(36'h500 + i));
            for (int i = 0; i < 40; i++) rd_ft();
        join
        repeat (8) @(negedge rclk);
        chk(rd_status == 1'b0 && model.size() == 0, "R9 stream complete", W'(model.size()), 0);

        finish_sim();
    end
endmodule